// File: doc/BRIEF.md
# Floating-Point Compare-Against-Zero Unit

This unit takes one scalar compare instruction word and one 64-bit operand value. It decides whether the operand, read as an IEEE-754 single or double, satisfies one of five relations against zero. The five relations are greater-or-equal, less-or-equal, greater-than, equal and less-than. The answer is a mask: every bit of the result width is set when the relation holds, and every bit is clear when it does not.

The unit never does floating-point arithmetic. It splits the operand into sign, exponent and mantissa and puts it in one of four classes: NaN, zero of either sign, negative non-zero or positive non-zero. Each predicate is then a small truth function of that class.

The instruction word is decoded in the same cycle. Any pattern the unit does not recognise sets an unallocated flag in place of a result. All outputs are registered, so a result appears one clock after its inputs. The source and destination register fields are passed through so that the surrounding pipeline can route the mask.

Top module: `fpz_cmp_unit`

## Requirements
- R1: Instruction bit 22 selects the precision. At 0 the operand is bits [31:0] read as a single, the mask covers bits [31:0] and bits [63:32] of the mask are zero. At 1 the operand is all 64 bits read as a double and the mask covers all 64 bits.
- R2: A true relation yields all ones across the result width, and a false one yields all zeros.
- R3: When bits [31:23] = 0x0FD, bits [15:10] = 0x32 selects greater-or-equal and 0x36 selects less-or-equal.
- R4: When bits [31:23] = 0x0BD, bits [15:10] = 0x32 selects greater-than, 0x36 selects equal and 0x3A selects less-than.
- R5: Any word that has bits [21:16] other than 0x20, or a [31:23]/[15:10] pair not listed in R3 or R4, raises the unallocated flag with valid low and the mask zero.
- R6: A NaN operand (exponent all ones, mantissa non-zero) makes every relation false.
- R7: +0 and -0 both equal zero, so greater-or-equal, less-or-equal and equal are true for them, and greater-than and less-than are false.
- R8: A denormal operand is non-zero and is positive or negative according to its sign bit.
- R9: An infinity compares by its sign: +inf is greater than zero and -inf is less than zero.
- R10: Outputs are registered with one cycle of latency. Under synchronous active-high reset, mask, valid and unallocated are all zero. After the first edge out of reset, exactly one of valid and unallocated is set.
- R11: The destination output carries instruction bits [4:0] and the source output carries bits [9:5], with the same latency as the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Compare instruction word |
| opnd_i | input | 64 | Operand value (low 32 bits used in single mode) |
| mask_o | output | 64 | All-ones or all-zeros comparison result |
| valid_o | output | 1 | Result is a recognised comparison |
| unalloc_o | output | 1 | Instruction word is not a recognised encoding |
| src_o | output | 5 | Operand register index from the word |
| dst_o | output | 5 | Destination register index from the word |

## Verification
Suppose the decoder or the classifier held a wrong state, such as a mis-mapped predicate, a precision select read from the wrong bit, or a NaN taken for a number. The fault would show up in the mask exactly one clock after the offending word, as a word that should have been full or empty and is not, or as a mask width that does not match bit 22. The hard cases are the ones where classes meet: signed zeros under strict and non-strict relations, smallest denormals, infinities and NaNs with garbage in the unused upper half. A decode fault also shows at once as the wrong choice between valid and unallocated.

// File: rtl/fpz_pkg.sv
package fpz_pkg;

    localparam int INSN_W   = 32;
    localparam int DATA_W   = 64;
    localparam int SGL_W    = 32;
    localparam int SGL_EXP  = 8;
    localparam int SGL_MAN  = 23;
    localparam int DBL_EXP  = 11;
    localparam int DBL_MAN  = 52;
    localparam int REG_W    = 5;
    localparam int NUM_PREC = 2;

    // encoding constants that select the relation
    localparam logic [8:0] GRP_ORD  = 9'h0FD;
    localparam logic [8:0] GRP_STR  = 9'h0BD;
    localparam logic [5:0] MID_FIX  = 6'h20;
    localparam logic [5:0] OPC_LOW  = 6'h32;
    localparam logic [5:0] OPC_MID  = 6'h36;
    localparam logic [5:0] OPC_HIGH = 6'h3A;

    typedef enum logic [2:0] {
        PRD_GE = 3'd0,
        PRD_LE = 3'd1,
        PRD_GT = 3'd2,
        PRD_EQ = 3'd3,
        PRD_LT = 3'd4
    } pred_e;

    typedef struct packed {
        logic             legal;
        pred_e            pred;
        logic             dbl;
        logic [REG_W-1:0] src;
        logic [REG_W-1:0] dst;
    } dec_s;

    typedef struct packed {
        logic nan;
        logic zero;
        logic neg;
    } cls_s;

    // truth of a relation for an operand class
    function automatic logic pred_hit(input pred_e p, input cls_s c);
        logic pos_nz;
        logic neg_nz;
        pos_nz = !c.nan && !c.zero && !c.neg;
        neg_nz = !c.nan && !c.zero &&  c.neg;
        case (p)
            PRD_GE:  return c.zero || pos_nz;
            PRD_LE:  return c.zero || neg_nz;
            PRD_GT:  return pos_nz;
            PRD_EQ:  return c.zero;
            PRD_LT:  return neg_nz;
            default: return 1'b0;
        endcase
    endfunction

    // spread one truth bit over the width chosen by precision
    function automatic logic [DATA_W-1:0] spread(input logic dbl, input logic hit);
        logic [DATA_W-1:0] m;
        m = '0;
        if (hit) begin
            if (dbl) m = '1;
            else     m[SGL_W-1:0] = '1;
        end
        return m;
    endfunction

endpackage

// File: rtl/fpz_decode.sv
module fpz_decode
    import fpz_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output dec_s              dec_o
);
    logic [8:0] grp;
    logic [5:0] mid;
    logic [5:0] opc;

    assign grp = insn_i[31:23];
    assign mid = insn_i[21:16];
    assign opc = insn_i[15:10];

    always_comb begin
        dec_o.legal = 1'b0;
        dec_o.pred  = PRD_GE;
        dec_o.dbl   = insn_i[22];
        dec_o.src   = insn_i[9:5];
        dec_o.dst   = insn_i[4:0];
        if (mid == MID_FIX) begin
            if (grp == GRP_ORD) begin
                case (opc)
                    OPC_LOW: begin dec_o.legal = 1'b1; dec_o.pred = PRD_GE; end
                    OPC_MID: begin dec_o.legal = 1'b1; dec_o.pred = PRD_LE; end
                    default: dec_o.legal = 1'b0;
                endcase
            end else if (grp == GRP_STR) begin
                case (opc)
                    OPC_LOW:  begin dec_o.legal = 1'b1; dec_o.pred = PRD_GT; end
                    OPC_MID:  begin dec_o.legal = 1'b1; dec_o.pred = PRD_EQ; end
                    OPC_HIGH: begin dec_o.legal = 1'b1; dec_o.pred = PRD_LT; end
                    default:  dec_o.legal = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/fpz_classify.sv
module fpz_classify
    import fpz_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int VAL_W = EXP_W + MAN_W + 1
) (
    input  logic [VAL_W-1:0] val_i,
    output cls_s             cls_o
);
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] mant;

    assign expo = val_i[VAL_W-2 -: EXP_W];
    assign mant = val_i[MAN_W-1:0];

    always_comb begin
        cls_o.nan  = (&expo) && (|mant);
        cls_o.zero = ~(|expo) && ~(|mant);
        cls_o.neg  = val_i[VAL_W-1];
    end
endmodule

// File: rtl/fpz_cmp_unit.sv
module fpz_cmp_unit
    import fpz_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [DATA_W-1:0] opnd_i,
    output logic [DATA_W-1:0] mask_o,
    output logic              valid_o,
    output logic              unalloc_o,
    output logic [REG_W-1:0]  src_o,
    output logic [REG_W-1:0]  dst_o
);
    dec_s dec;
    cls_s cls_v [NUM_PREC];
    cls_s cls_sel;
    logic hit;
    logic [DATA_W-1:0] mask_nx;

    fpz_decode u_dec (
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    // one classifier per precision; index 0 single, index 1 double
    for (genvar g = 0; g < NUM_PREC; g++) begin : g_prec
        localparam int EW = (g == 0) ? SGL_EXP : DBL_EXP;
        localparam int MW = (g == 0) ? SGL_MAN : DBL_MAN;
        localparam int VW = EW + MW + 1;
        fpz_classify #(
            .EXP_W (EW),
            .MAN_W (MW)
        ) u_cls (
            .val_i (opnd_i[VW-1:0]),
            .cls_o (cls_v[g])
        );
    end

    always_comb begin
        cls_sel = dec.dbl ? cls_v[1] : cls_v[0];
        hit     = dec.legal && pred_hit(dec.pred, cls_sel);
        mask_nx = spread(dec.dbl, hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_o    <= '0;
            valid_o   <= 1'b0;
            unalloc_o <= 1'b0;
            src_o     <= '0;
            dst_o     <= '0;
        end else begin
            mask_o    <= mask_nx;
            valid_o   <= dec.legal;
            unalloc_o <= !dec.legal;
            src_o     <= dec.src;
            dst_o     <= dec.dst;
        end
    end
endmodule

module fpz_cmp_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [21:0] hi_i,
    input logic [4:0]  dst_f_i,
    input logic [62:0] val_i,
    input logic [63:0] mask_o,
    input logic        valid_o,
    input logic        unalloc_o,
    input logic [4:0]  dst_o
);
    logic dbl_in;
    logic nan_in;
    logic zero_in;
    logic eq_in;

    assign dbl_in  = hi_i[12];
    assign nan_in  = dbl_in ? ((&val_i[62:52]) && (|val_i[51:0]))
                            : ((&val_i[30:23]) && (|val_i[22:0]));
    assign zero_in = dbl_in ? (val_i[62:0] == '0) : (val_i[30:0] == '0);
    assign eq_in   = (hi_i[21:13] == 9'h0BD) && (hi_i[11:6] == 6'h20) && (hi_i[5:0] == 6'h36);

    // R1 / R2: mask is empty or full over the selected width
    p_mask_shape_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (mask_o == '0) ||
                 ((mask_o == {64{1'b1}}) && $past(dbl_in)) ||
                 ((mask_o == 64'h0000_0000_FFFF_FFFF) && !$past(dbl_in)));

    // R5: an unrecognised word gives no result
    p_unalloc_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        unalloc_o |-> (mask_o == '0) && !valid_o);

    // R6: NaN makes every relation false
    p_nan_false_r6: assert property (@(posedge clk) disable iff (rst)
        nan_in |=> (mask_o == '0));

    // R7: either zero is equal to zero
    p_zero_equal_r7: assert property (@(posedge clk) disable iff (rst)
        (eq_in && zero_in) |=> (mask_o != '0));

    // R10: exactly one flag once out of reset
    p_one_flag_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (valid_o ^ unalloc_o));

    // R11: destination index follows the word by one cycle
    p_dst_follow_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (dst_o == $past(dst_f_i)));
endmodule

bind fpz_cmp_unit fpz_cmp_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .hi_i      (insn_i[31:10]),
    .dst_f_i   (insn_i[4:0]),
    .val_i     (opnd_i[62:0]),
    .mask_o    (mask_o),
    .valid_o   (valid_o),
    .unalloc_o (unalloc_o),
    .dst_o     (dst_o)
);

// File: tb/fpz_cmp_unit_test.sv
module fpz_cmp_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] insn = '0;
    logic [63:0] opnd = '0;
    logic [63:0] mask;
    logic        vld;
    logic        una;
    logic [4:0]  src;
    logic [4:0]  dst;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;   // 250 MHz

    fpz_cmp_unit uut (
        .clk       (clk),
        .rst       (rst),
        .insn_i    (insn),
        .opnd_i    (opnd),
        .mask_o    (mask),
        .valid_o   (vld),
        .unalloc_o (una),
        .src_o     (src),
        .dst_o     (dst)
    );

    // bench predicate code: 0 GE, 1 LE, 2 GT, 3 EQ, 4 LT
    typedef struct packed {
        logic [2:0]  pc;
        logic        dbl;
        logic [63:0] val;
        logic        tru;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 1'b0, 64'hDEADBEEF_3F800000, 1'b1, 4'd3},  // R3 GE +1
        '{3'd0, 1'b0, 64'h00000000_BF800000, 1'b0, 4'd3},  // R3 GE -1
        '{3'd0, 1'b0, 64'h00000000_00000000, 1'b1, 4'd7},  // R7 GE +0
        '{3'd0, 1'b0, 64'hFFFFFFFF_80000000, 1'b1, 4'd7},  // R7 GE -0
        '{3'd0, 1'b0, 64'h00000000_7FC00000, 1'b0, 4'd6},  // R6 GE NaN
        '{3'd1, 1'b0, 64'h12345678_BF800000, 1'b1, 4'd3},  // R3 LE -1
        '{3'd1, 1'b0, 64'h00000000_3F800000, 1'b0, 4'd3},  // R3 LE +1
        '{3'd1, 1'b0, 64'h00000000_80000000, 1'b1, 4'd7},  // R7 LE -0
        '{3'd2, 1'b0, 64'h00000000_3F800000, 1'b1, 4'd4},  // R4 GT +1
        '{3'd2, 1'b0, 64'h00000000_00000000, 1'b0, 4'd7},  // R7 GT +0
        '{3'd2, 1'b0, 64'h00000000_80000000, 1'b0, 4'd7},  // R7 GT -0
        '{3'd2, 1'b0, 64'h00000000_7F800000, 1'b1, 4'd9},  // R9 GT +inf
        '{3'd2, 1'b0, 64'h00000000_00000001, 1'b1, 4'd8},  // R8 GT +denormal
        '{3'd3, 1'b0, 64'h00000000_80000000, 1'b1, 4'd7},  // R7 EQ -0
        '{3'd3, 1'b0, 64'hDEADBEEF_00000000, 1'b1, 4'd7},  // R7 EQ +0, upper ignored
        '{3'd3, 1'b0, 64'h00000000_00000001, 1'b0, 4'd8},  // R8 EQ denormal
        '{3'd3, 1'b0, 64'h00000000_FFC00001, 1'b0, 4'd6},  // R6 EQ NaN
        '{3'd4, 1'b0, 64'h00000000_BF800000, 1'b1, 4'd4},  // R4 LT -1
        '{3'd4, 1'b0, 64'h00000000_80000001, 1'b1, 4'd8},  // R8 LT -denormal
        '{3'd4, 1'b0, 64'h00000000_FF800000, 1'b1, 4'd9},  // R9 LT -inf
        '{3'd4, 1'b0, 64'h00000000_80000000, 1'b0, 4'd7},  // R7 LT -0
        '{3'd0, 1'b1, 64'hC000000000000000, 1'b0, 4'd1},   // R1 GE dbl -2
        '{3'd0, 1'b1, 64'h0000000000000000, 1'b1, 4'd1},   // R1 GE dbl +0
        '{3'd1, 1'b1, 64'h8000000000000000, 1'b1, 4'd7},   // R7 LE dbl -0
        '{3'd2, 1'b1, 64'h7FF0000000000000, 1'b1, 4'd9},   // R9 GT dbl +inf
        '{3'd2, 1'b1, 64'h7FF8000000000001, 1'b0, 4'd6},   // R6 GT dbl NaN
        '{3'd3, 1'b1, 64'h8000000000000000, 1'b1, 4'd7},   // R7 EQ dbl -0
        '{3'd3, 1'b1, 64'h0000000000000001, 1'b0, 4'd8},   // R8 EQ dbl denormal
        '{3'd4, 1'b1, 64'hFFF0000000000000, 1'b1, 4'd9},   // R9 LT dbl -inf
        '{3'd4, 1'b1, 64'h8000000000000001, 1'b1, 4'd8},   // R8 LT dbl -denormal
        '{3'd4, 1'b1, 64'h3FF0000000000000, 1'b0, 4'd2},   // R2 LT dbl +1
        '{3'd1, 1'b1, 64'h7FF0000000000010, 1'b0, 4'd6}    // R6 LE dbl NaN
    };

    function automatic logic [31:0] mk(input logic [2:0] pc, input logic dbl,
                                       input logic [4:0] rn, input logic [4:0] rd);
        logic [8:0] grp;
        logic [5:0] opc;
        grp = (pc < 3'd2) ? 9'h0FD : 9'h0BD;
        case (pc)
            3'd0, 3'd2: opc = 6'h32;
            3'd1, 3'd3: opc = 6'h36;
            default:    opc = 6'h3A;
        endcase
        return {grp, dbl, 6'h20, opc, rn, rd};
    endfunction

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge
    task automatic apply(input logic [31:0] w, input logic [63:0] v);
        @(negedge clk);
        insn = w;
        opnd = v;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] em;
        // R10: reset state even with a legal word applied
        insn = mk(3'd3, 1'b1, 5'd1, 5'd2);
        opnd = '0;
        repeat (3) @(negedge clk);
        check("R10 reset mask", mask, '0);
        check("R10 reset flags", {62'd0, vld, una}, '0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(mk(VEC[i].pc, VEC[i].dbl, 5'(i), 5'(31 - i)), VEC[i].val);
            em = VEC[i].tru ? (VEC[i].dbl ? {64{1'b1}} : 64'h0000_0000_FFFF_FFFF) : '0;
            check($sformatf("R%0d vec %0d mask", VEC[i].rq, i), mask, em);
            check("R2 valid", {63'd0, vld}, 64'd1);
        end

        // R11: register indices pass through
        apply(mk(3'd0, 1'b0, 5'd17, 5'd9), 64'h0);
        check("R11 dst", {59'd0, dst}, 64'd9);
        check("R11 src", {59'd0, src}, 64'd17);

        // R5: wrong middle field
        apply(mk(3'd0, 1'b0, 5'd0, 5'd0) ^ 32'h0001_0000, 64'h0);
        check("R5 bad mid flags", {62'd0, vld, una}, 64'd1);
        check("R5 bad mid mask", mask, '0);
        // R5: less-than opcode under the ordered group
        apply({9'h0FD, 1'b1, 6'h20, 6'h3A, 10'd0}, 64'h8000000000000001);
        check("R5 bad opcode flags", {62'd0, vld, una}, 64'd1);
        check("R5 bad opcode mask", mask, '0);
        // R5: unknown group
        apply({9'h0FC, 1'b0, 6'h20, 6'h36, 10'd0}, 64'h0);
        check("R5 bad group flags", {62'd0, vld, una}, 64'd1);

        // R4: recovers after unallocated, single width stays 32 bits (R1)
        apply(mk(3'd4, 1'b0, 5'd0, 5'd0), 64'hFFFFFFFF_BF800000);
        check("R1 single width", mask, 64'h0000_0000_FFFF_FFFF);

        // R10: one-cycle latency; new input not visible before the edge
        @(negedge clk);
        insn = mk(3'd2, 1'b1, 5'd0, 5'd0);
        opnd = 64'h3FF0000000000000;
        #1;
        check("R10 latency hold", mask, 64'h0000_0000_FFFF_FFFF);
        @(negedge clk);
        check("R10 latency update", mask, {64{1'b1}});

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule